// File: doc/BRIEF.md
# Flash Block Remapper with Wear Leveling

This block sits between a host and a small flash array and translates logical block numbers into physical block numbers. The array has more physical blocks than the host can see (16 physical behind 12 logical by default), and the spare blocks form a free pool. Reads are answered straight from the translation table. Writes are never done in place. Each write is steered to a fresh erased block chosen by erase count. The table is then relinked, and the block that was given up is marked stale until it is erased for reuse.

The block drives a single-outstanding flash command port carrying check, erase and program operations, and takes back a done pulse with a pass/fail flag. After reset it checks every physical block once and retires the failing ones. A failed program retires the target block and retries the write on another block. Every few host writes it compares the spread of erase counts. If the spread is too wide, it moves the coldest mapped block so that its lightly worn physical block returns to the pool. When no usable block is left, the write is refused and the table is left as it was.

Top module: `flwl_remap`

## Requirements
- R1: After reset the table is the identity (logical l on physical l). Physical blocks NLOG and up are free. The block issues exactly one check command (op code 0) to every physical block, in ascending order, and marks each block whose check fails as bad. req_ready stays low until all checks are done.
- R2: A read of logical block l < NLOG gives resp_valid one cycle after the request is taken, with resp_err = 0 and resp_pblk equal to the current mapping of l.
- R3: A write of logical block l < NLOG chooses, among blocks that are free or stale and not bad, the one with the lowest erase count, with ties going to the lowest physical index. It programs that block (op code 2), relinks l to it and responds with resp_err = 0 and resp_pblk set to the new block. A block that currently holds mapped data is never programmed.
- R4: The block that l previously mapped to becomes stale. A stale block is erased (op code 1) right before it is programmed, and each erase that passes adds one to that block's erase count.
- R5: When a program fails, its target block is marked bad, and the same request goes on with the next choice under R3.
- R6: A block marked bad, whether by the initial check or by a failed operation, never receives another erase or program command.
- R7: When no candidate block is left, the write responds with resp_err = 1 and resp_pblk set to the unchanged current mapping of l, and the table entry of l keeps its value.
- R8: A request with a logical index of NLOG or above responds one cycle later with resp_err = 1 and resp_pblk = 0, and no flash command is issued for it.
- R9: After every RELOC_EVERY-th successful host write, the block computes two values: the highest erase count over non-bad blocks and the lowest erase count over mapped blocks. If the first minus the second exceeds GAP_THR, it moves the logical block whose physical block has that lowest count (lowest index on ties) under the rules of R3 to R5. It sends no response for this move and keeps req_ready low while it runs.
- R10: When no relocation happens, a logical block that is never written keeps its physical block.
- R11: At most one flash command is outstanding at a time, and no command is issued while req_ready is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Host request strobe, taken when req_ready is high |
| req_write | input | 1 | 1 = write, 0 = read |
| req_lblk | input | $clog2(NLOG) | Logical block number |
| req_ready | output | 1 | Block idle and able to take a request |
| resp_valid | output | 1 | One-cycle response strobe |
| resp_err | output | 1 | Out-of-range index or no usable block |
| resp_pblk | output | $clog2(NPHYS) | Physical block of the response |
| fl_cmd_valid | output | 1 | One-cycle flash command strobe |
| fl_cmd_op | output | 2 | 0 check, 1 erase, 2 program |
| fl_cmd_blk | output | $clog2(NPHYS) | Physical block of the command |
| fl_done | input | 1 | Flash command finished |
| fl_fail | input | 1 | Status of the finished command, 1 = fail |

## Verification
The hardest situation to reach is the exhausted pool. Getting there needs the bad-block map built at reset and the program failures inside one write to remove every candidate, and the table must come out untouched. The bench resets the block with the check failing on all but one spare block and with every program failing. A single write then retires the last spare and has to be refused. Static relocation depends on an erase-count gap that builds up slowly, so a long random mix of writes follows. That mix is weighted toward a few hot logical blocks while the others stay cold, and full table sweeps compare against a reference model that tracks the same counts.

// File: rtl/flwl_pkg.sv
package flwl_pkg;
  typedef enum logic [1:0] {
    BS_FREE  = 2'd0,
    BS_VALID = 2'd1,
    BS_STALE = 2'd2,
    BS_BAD   = 2'd3
  } blk_st_e;

  typedef enum logic [1:0] {
    OP_CHECK = 2'd0,
    OP_ERASE = 2'd1,
    OP_PROG  = 2'd2
  } fl_op_e;
endpackage

// File: rtl/flwl_alloc.sv
module flwl_alloc
  import flwl_pkg::*;
#(
  parameter int NPHYS = 16,
  parameter int CNTW  = 8,
  parameter int PW    = $clog2(NPHYS)
) (
  input  blk_st_e         st_i [NPHYS],
  input  logic [CNTW-1:0] ec_i [NPHYS],
  output logic            found_o,
  output logic [PW-1:0]   pick_o
);
  logic [CNTW-1:0] best;

  always_comb begin
    found_o = 1'b0;
    pick_o  = '0;
    best    = '0;
    for (int i = 0; i < NPHYS; i++) begin
      if ((st_i[i] == BS_FREE || st_i[i] == BS_STALE) &&
          (!found_o || ec_i[i] < best)) begin
        found_o = 1'b1;
        pick_o  = PW'(i);
        best    = ec_i[i];
      end
    end
  end
endmodule

// File: rtl/flwl_wear.sv
module flwl_wear
  import flwl_pkg::*;
#(
  parameter int NPHYS   = 16,
  parameter int NLOG    = 12,
  parameter int CNTW    = 8,
  parameter int GAP_THR = 3,
  parameter int PW      = $clog2(NPHYS),
  parameter int LW      = $clog2(NLOG)
) (
  input  blk_st_e         st_i  [NPHYS],
  input  logic [CNTW-1:0] ec_i  [NPHYS],
  input  logic [PW-1:0]   map_i [NLOG],
  output logic            hit_o,
  output logic [LW-1:0]   cold_l_o
);
  logic            have, lfound;
  logic [CNTW-1:0] mn, mx;
  logic [PW-1:0]   cold_p;

  always_comb begin
    have   = 1'b0;
    mn     = '0;
    mx     = '0;
    cold_p = '0;
    for (int i = 0; i < NPHYS; i++) begin
      if (st_i[i] != BS_BAD && ec_i[i] > mx) mx = ec_i[i];
      if (st_i[i] == BS_VALID && (!have || ec_i[i] < mn)) begin
        have   = 1'b1;
        mn     = ec_i[i];
        cold_p = PW'(i);
      end
    end
    lfound   = 1'b0;
    cold_l_o = '0;
    for (int l = 0; l < NLOG; l++) begin
      if (!lfound && map_i[l] == cold_p) begin
        lfound   = 1'b1;
        cold_l_o = LW'(l);
      end
    end
    hit_o = have && lfound && ((mx - mn) > CNTW'(GAP_THR));
  end
endmodule

// File: rtl/flwl_remap.sv
module flwl_remap
  import flwl_pkg::*;
#(
  parameter int NPHYS       = 16,
  parameter int NLOG        = 12,
  parameter int CNTW        = 8,
  parameter int RELOC_EVERY = 4,
  parameter int GAP_THR     = 3,
  localparam int PW  = $clog2(NPHYS),
  localparam int LW  = $clog2(NLOG),
  localparam int WCW = $clog2(RELOC_EVERY + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          req_valid,
  input  logic          req_write,
  input  logic [LW-1:0] req_lblk,
  output logic          req_ready,
  output logic          resp_valid,
  output logic          resp_err,
  output logic [PW-1:0] resp_pblk,
  output logic          fl_cmd_valid,
  output logic [1:0]    fl_cmd_op,
  output logic [PW-1:0] fl_cmd_blk,
  input  logic          fl_done,
  input  logic          fl_fail
);
  typedef enum logic [2:0] {
    S_INIT, S_INITW, S_IDLE, S_PICK, S_ERW, S_PRW, S_RELOC
  } fsm_e;

  fsm_e            state;
  blk_st_e         st_q  [NPHYS];
  logic [CNTW-1:0] ec_q  [NPHYS];
  logic [PW-1:0]   map_q [NLOG];
  logic [PW-1:0]   idx_q, tgt_q;
  logic [LW-1:0]   cur_l;
  logic            is_reloc;
  logic [WCW-1:0]  wcnt;

  logic            found, hit;
  logic [PW-1:0]   pick;
  logic [LW-1:0]   cold_l;

  flwl_alloc #(.NPHYS(NPHYS), .CNTW(CNTW), .PW(PW)) u_alloc (
    .st_i(st_q), .ec_i(ec_q), .found_o(found), .pick_o(pick)
  );

  flwl_wear #(.NPHYS(NPHYS), .NLOG(NLOG), .CNTW(CNTW), .GAP_THR(GAP_THR),
              .PW(PW), .LW(LW)) u_wear (
    .st_i(st_q), .ec_i(ec_q), .map_i(map_q), .hit_o(hit), .cold_l_o(cold_l)
  );

  assign req_ready = (state == S_IDLE);

  always_ff @(posedge clk) begin
    resp_valid   <= 1'b0;
    fl_cmd_valid <= 1'b0;
    if (rst) begin
      state      <= S_INIT;
      idx_q      <= '0;
      tgt_q      <= '0;
      cur_l      <= '0;
      is_reloc   <= 1'b0;
      wcnt       <= '0;
      resp_err   <= 1'b0;
      resp_pblk  <= '0;
      fl_cmd_op  <= '0;
      fl_cmd_blk <= '0;
      for (int p = 0; p < NPHYS; p++) begin
        st_q[p] <= (p < NLOG) ? BS_VALID : BS_FREE;
        ec_q[p] <= '0;
      end
      for (int l = 0; l < NLOG; l++) map_q[l] <= PW'(l);
    end else begin
      case (state)
        S_INIT: begin
          fl_cmd_valid <= 1'b1;
          fl_cmd_op    <= OP_CHECK;
          fl_cmd_blk   <= idx_q;
          state        <= S_INITW;
        end
        S_INITW: if (fl_done) begin
          if (fl_fail) st_q[idx_q] <= BS_BAD;
          if (idx_q == PW'(NPHYS - 1)) state <= S_IDLE;
          else begin
            idx_q <= idx_q + 1'b1;
            state <= S_INIT;
          end
        end
        S_IDLE: if (req_valid) begin
          if ({1'b0, req_lblk} >= (LW + 1)'(NLOG)) begin
            resp_valid <= 1'b1;
            resp_err   <= 1'b1;
            resp_pblk  <= '0;
          end else if (!req_write) begin
            resp_valid <= 1'b1;
            resp_err   <= 1'b0;
            resp_pblk  <= map_q[req_lblk];
          end else begin
            cur_l    <= req_lblk;
            is_reloc <= 1'b0;
            state    <= S_PICK;
          end
        end
        S_PICK: begin
          if (!found) begin
            if (!is_reloc) begin
              resp_valid <= 1'b1;
              resp_err   <= 1'b1;
              resp_pblk  <= map_q[cur_l];
            end
            state <= S_IDLE;
          end else begin
            tgt_q        <= pick;
            fl_cmd_valid <= 1'b1;
            fl_cmd_blk   <= pick;
            if (st_q[pick] == BS_STALE) begin
              fl_cmd_op <= OP_ERASE;
              state     <= S_ERW;
            end else begin
              fl_cmd_op <= OP_PROG;
              state     <= S_PRW;
            end
          end
        end
        S_ERW: if (fl_done) begin
          if (fl_fail) begin
            st_q[tgt_q] <= BS_BAD;
            state       <= S_PICK;
          end else begin
            if (ec_q[tgt_q] != '1) ec_q[tgt_q] <= ec_q[tgt_q] + 1'b1;
            st_q[tgt_q]  <= BS_FREE;
            fl_cmd_valid <= 1'b1;
            fl_cmd_op    <= OP_PROG;
            fl_cmd_blk   <= tgt_q;
            state        <= S_PRW;
          end
        end
        S_PRW: if (fl_done) begin
          if (fl_fail) begin
            st_q[tgt_q] <= BS_BAD;
            state       <= S_PICK;
          end else begin
            if (st_q[map_q[cur_l]] != BS_BAD) st_q[map_q[cur_l]] <= BS_STALE;
            st_q[tgt_q]  <= BS_VALID;
            map_q[cur_l] <= tgt_q;
            if (is_reloc) state <= S_IDLE;
            else begin
              resp_valid <= 1'b1;
              resp_err   <= 1'b0;
              resp_pblk  <= tgt_q;
              if (wcnt == WCW'(RELOC_EVERY - 1)) begin
                wcnt  <= '0;
                state <= S_RELOC;
              end else begin
                wcnt  <= wcnt + 1'b1;
                state <= S_IDLE;
              end
            end
          end
        end
        S_RELOC: begin
          if (hit) begin
            cur_l    <= cold_l;
            is_reloc <= 1'b1;
            state    <= S_PICK;
          end else state <= S_IDLE;
        end
        default: state <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/flwl_remap_chk.sv
module flwl_remap_chk
  import flwl_pkg::*;
#(
  parameter int NPHYS = 16,
  parameter int CNTW  = 8,
  parameter int PW    = $clog2(NPHYS)
) (
  input logic            clk,
  input logic            rst,
  input logic            req_ready,
  input logic            resp_valid,
  input logic            resp_err,
  input logic [PW-1:0]   resp_pblk,
  input logic            fl_cmd_valid,
  input logic [1:0]      fl_cmd_op,
  input logic [PW-1:0]   fl_cmd_blk,
  input blk_st_e         st [NPHYS],
  input logic [CNTW-1:0] ec [NPHYS]
);
  AST_CMD_SINGLE: assert property (@(posedge clk) disable iff (rst)
    fl_cmd_valid |=> !fl_cmd_valid); // R11
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
    req_ready |-> !fl_cmd_valid); // R11
  AST_PROG_FREE: assert property (@(posedge clk) disable iff (rst)
    (fl_cmd_valid && fl_cmd_op == 2'd2) |-> st[fl_cmd_blk] == BS_FREE); // R3
  AST_ERASE_STALE: assert property (@(posedge clk) disable iff (rst)
    (fl_cmd_valid && fl_cmd_op == 2'd1) |-> st[fl_cmd_blk] == BS_STALE); // R4
  AST_RESP_MAPPED: assert property (@(posedge clk) disable iff (rst)
    (resp_valid && !resp_err) |->
      (st[resp_pblk] != BS_FREE && st[resp_pblk] != BS_STALE)); // R2

  for (genvar p = 0; p < NPHYS; p++) begin : g_blk
    AST_BAD_STICKY: assert property (@(posedge clk) disable iff (rst)
      st[p] == BS_BAD |=> st[p] == BS_BAD); // R6
    AST_EC_MONO: assert property (@(posedge clk) disable iff (rst)
      1'b1 |=> ec[p] >= $past(ec[p])); // R4
  end
endmodule

bind flwl_remap flwl_remap_chk #(.NPHYS(NPHYS), .CNTW(CNTW), .PW(PW)) u_chk (
  .clk(clk), .rst(rst), .req_ready(req_ready), .resp_valid(resp_valid),
  .resp_err(resp_err), .resp_pblk(resp_pblk), .fl_cmd_valid(fl_cmd_valid),
  .fl_cmd_op(fl_cmd_op), .fl_cmd_blk(fl_cmd_blk), .st(st_q), .ec(ec_q)
);

// File: tb/tb_flwl_remap.sv
module tb_flwl_remap;
  localparam int NPHYS = 16;
  localparam int NLOG  = 12;
  localparam int RELOC_EVERY = 4;
  localparam int GAP_THR = 3;
  localparam int PW = $clog2(NPHYS);
  localparam int LW = $clog2(NLOG);

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic req_valid = 1'b0, req_write = 1'b0;
  logic [LW-1:0] req_lblk = '0;
  logic req_ready, resp_valid, resp_err;
  logic [PW-1:0] resp_pblk;
  logic fl_cmd_valid;
  logic [1:0] fl_cmd_op;
  logic [PW-1:0] fl_cmd_blk;
  logic fl_done = 1'b0, fl_fail = 1'b0;

  always #2 clk = ~clk;

  flwl_remap #(.NPHYS(NPHYS), .NLOG(NLOG), .RELOC_EVERY(RELOC_EVERY),
               .GAP_THR(GAP_THR)) dut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
    .req_lblk(req_lblk), .req_ready(req_ready), .resp_valid(resp_valid),
    .resp_err(resp_err), .resp_pblk(resp_pblk), .fl_cmd_valid(fl_cmd_valid),
    .fl_cmd_op(fl_cmd_op), .fl_cmd_blk(fl_cmd_blk), .fl_done(fl_done),
    .fl_fail(fl_fail)
  );

  int n_chk = 0, n_bad = 0;
  bit chk_fail [NPHYS];
  bit prg_fail [NPHYS];

  // ---------------- behavioural flash ----------------
  int lat = 0;
  logic [1:0] mop;
  logic [PW-1:0] mblk;
  bit erased [NPHYS];
  bit mdead [NPHYS];
  int m_cmds = 0, m_checks = 0, m_viol = 0, m_seen = 0;

  always @(posedge clk) begin
    fl_done <= 1'b0;
    fl_fail <= 1'b0;
    if (rst) begin
      lat <= 0;
      m_cmds <= 0;
      m_checks <= 0;
      for (int p = 0; p < NPHYS; p++) begin
        erased[p] <= (p >= NLOG);
        mdead[p]  <= 1'b0;
      end
    end else begin
      if (fl_cmd_valid) begin
        m_seen <= m_seen + 1;
        if (lat != 0) begin
          $display("FAIL R11: command while busy, actual lat=%0d expected 0", lat);
          m_viol <= m_viol + 1;
        end
        if (fl_cmd_op != 2'd0 && mdead[fl_cmd_blk]) begin
          $display("FAIL R6: op %0d to retired block %0d, actual issued expected none",
                   fl_cmd_op, fl_cmd_blk);
          m_viol <= m_viol + 1;
        end
        if (fl_cmd_op == 2'd2 && !erased[fl_cmd_blk]) begin
          $display("FAIL R4: program of unerased block %0d, actual erased=0 expected 1",
                   fl_cmd_blk);
          m_viol <= m_viol + 1;
        end
        m_cmds <= m_cmds + 1;
        if (fl_cmd_op == 2'd0) m_checks <= m_checks + 1;
        lat  <= 3;
        mop  <= fl_cmd_op;
        mblk <= fl_cmd_blk;
      end else if (lat > 0) begin
        lat <= lat - 1;
        if (lat == 1) begin
          fl_done <= 1'b1;
          if (mop == 2'd0) begin
            fl_fail <= chk_fail[mblk];
            if (chk_fail[mblk]) mdead[mblk] <= 1'b1;
          end else if (mop == 2'd1) erased[mblk] <= 1'b1;
          else begin
            erased[mblk] <= 1'b0;
            fl_fail <= prg_fail[mblk];
            if (prg_fail[mblk]) mdead[mblk] <= 1'b1;
          end
        end
      end
    end
  end

  // ---------------- reference model ----------------
  int rs [NPHYS];   // 0 free 1 mapped 2 stale 3 bad
  int rec [NPHYS];
  int rmap [NLOG];
  int rw;

  function automatic void ref_reset();
    for (int p = 0; p < NPHYS; p++) begin
      rs[p]  = chk_fail[p] ? 3 : ((p < NLOG) ? 1 : 0);
      rec[p] = 0;
    end
    for (int l = 0; l < NLOG; l++) rmap[l] = l;
    rw = 0;
  endfunction

  function automatic bit ref_move(int l, output int np);
    np = 0;
    forever begin
      int best = -1;
      for (int p = 0; p < NPHYS; p++)
        if ((rs[p] == 0 || rs[p] == 2) && (best < 0 || rec[p] < rec[best])) best = p;
      if (best < 0) return 1'b0;
      if (rs[best] == 2) begin
        rec[best]++;
        rs[best] = 0;
      end
      if (prg_fail[best]) rs[best] = 3;
      else begin
        if (rs[rmap[l]] != 3) rs[rmap[l]] = 2;
        rs[best] = 1;
        rmap[l] = best;
        np = best;
        return 1'b1;
      end
    end
  endfunction

  function automatic void ref_write(int l, output bit err, output int p);
    bit ok;
    int dummy;
    if (l >= NLOG) begin
      err = 1'b1;
      p = 0;
      return;
    end
    ok = ref_move(l, p);
    err = !ok;
    if (!ok) begin
      p = rmap[l];
      return;
    end
    rw++;
    if (rw == RELOC_EVERY) begin
      int mx = 0, mn = 0, cp = -1, cl = -1;
      rw = 0;
      for (int q = 0; q < NPHYS; q++) begin
        if (rs[q] != 3 && rec[q] > mx) mx = rec[q];
        if (rs[q] == 1 && (cp < 0 || rec[q] < mn)) begin
          cp = q;
          mn = rec[q];
        end
      end
      for (int k = NLOG - 1; k >= 0; k--) if (rmap[k] == cp) cl = k;
      if (cp >= 0 && cl >= 0 && (mx - mn) > GAP_THR) void'(ref_move(cl, dummy));
    end
  endfunction

  // ---------------- helpers ----------------
  task automatic check(bit cond, string req, int act, int exp);
    n_chk++;
    if (!cond) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wait_ready();
    int n = 0;
    while (!req_ready && n < 2000) begin
      @(negedge clk);
      n++;
    end
    if (!req_ready) check(1'b0, "R11 ready timeout", 0, 1);
  endtask

  task automatic do_read(int l, string req);
    int c0;
    wait_ready();
    c0 = m_seen;
    req_write = 1'b0;
    req_lblk  = LW'(l);
    req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    check(resp_valid == 1'b1, {req, " resp_valid"}, int'(resp_valid), 1);
    if (l >= NLOG) begin
      check(resp_err == 1'b1 && resp_pblk == 0, "R8 read err", int'(resp_err), 1);
    end else begin
      check(resp_err == 1'b0, {req, " err"}, int'(resp_err), 0);
      check(int'(resp_pblk) == rmap[l], {req, " pblk"}, int'(resp_pblk), rmap[l]);
    end
    @(negedge clk);
    if (l >= NLOG) check(m_seen == c0, "R8 no command", m_seen - c0, 0);
  endtask

  task automatic do_write(int l, string req);
    bit eerr;
    int ep, n, c0;
    wait_ready();
    c0 = m_seen;
    ref_write(l, eerr, ep);
    req_write = 1'b1;
    req_lblk  = LW'(l);
    req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    n = 0;
    while (!resp_valid && n < 1000) begin
      @(negedge clk);
      n++;
    end
    check(resp_valid == 1'b1, {req, " write resp"}, int'(resp_valid), 1);
    check(resp_err == eerr, {req, " write err"}, int'(resp_err), int'(eerr));
    check(int'(resp_pblk) == ep, {req, " write pblk"}, int'(resp_pblk), ep);
    if (l >= NLOG) begin
      @(negedge clk);
      check(m_seen == c0, "R8 no command on write", m_seen - c0, 0);
    end
  endtask

  task automatic sweep(string req);
    for (int l = 0; l < NLOG; l++) do_read(l, req);
  endtask

  task automatic do_reset();
    rst = 1'b1;
    repeat (3) @(negedge clk);
    ref_reset();
    rst = 1'b0;
    @(negedge clk);
    check(req_ready == 1'b0, "R1 ready low during init", int'(req_ready), 0);
    check(resp_valid == 1'b0, "R1 no response after reset", int'(resp_valid), 0);
    wait_ready();
    check(m_checks == NPHYS, "R1 check count", m_checks, NPHYS);
  endtask

  // ---------------- watchdog ----------------
  initial begin
    repeat (190000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual expired expected done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  // ---------------- stimulus ----------------
  initial begin
    void'($urandom(32'h1d2c3b4a));
    for (int p = 0; p < NPHYS; p++) begin
      chk_fail[p] = 1'b0;
      prg_fail[p] = 1'b0;
    end
    // phase 1: one spare fails the check, one fails programming
    chk_fail[14] = 1'b1;
    prg_fail[13] = 1'b1;
    do_reset();
    sweep("R1 identity");
    do_read(12, "R8");
    do_read(15, "R8");
    do_write(0, "R3");
    do_write(0, "R4");
    do_read(5, "R10 cold block stays");
    do_write(1, "R5");
    do_write(13, "R8");
    sweep("R2");
    // random mix, hot set of logical blocks 0..3
    for (int i = 0; i < 300; i++) begin
      int r = int'($urandom_range(0, 99));
      int l = (r < 60) ? int'($urandom_range(0, 3)) : int'($urandom_range(0, NLOG + 1));
      if (r % 3 == 0) do_read(l, "R2");
      else do_write(l, "R3");
      if (i % 40 == 39) sweep("R9 table after relocation");
    end
    sweep("R9 final table");

    // phase 2: pool nearly empty and every program fails
    for (int p = 0; p < NPHYS; p++) begin
      chk_fail[p] = (p >= 12 && p <= 14);
      prg_fail[p] = 1'b1;
    end
    do_reset();
    do_write(3, "R7");
    do_read(3, "R7 table unchanged");
    do_write(3, "R7 again");
    do_read(7, "R2");

    wait_ready();
    repeat (5) @(negedge clk);
    check(m_viol == 0, "R6 flash model violations", m_viol, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule